// File: doc/BRIEF.md
# ECC Error Status and Interrupt Unit

This block is the software-visible record of memory errors for a SECDED-protected memory datapath. The decoder beside it reports each read that needed a single-bit correction, each read with an uncorrectable double-bit error, and each correction that could not be carried out. Every report comes as a one-cycle pulse with the failing address. The unit turns these pulses into sticky status flags, two saturating error counters and one captured error address. It drives a level interrupt that software can enable, and each error source has its own mask.

Software reaches the unit through a simple register port. Writes take effect on the clock edge, and reads are combinational. One interrupt-register command clears the pending status and the counters, and can re-arm the interrupt in the same write. For testing, two control bits make the write path store corrupted codewords, with one bit or two bits inverted. A later read of such a word then raises the matching error event. The unit also reports the codeword width of the datapath: data bits plus check bits.

Top module: `ecc_err_unit`

## Requirements
- R1: After reset, every register reads 0 except the width register, `irq` is low, and `wr_code_out` equals `wr_code_in`.
- R2: Offset 0x00 stores only bit 10 (ECC enable, on `ecc_en`), bit 11 (correction enable, on `corr_en`), bit 13 (single-flip injection) and bit 14 (double-flip injection), and reads every other bit as 0. Offset 0x30 reads DATA_W+ECC_W (40 by default). Unmapped offsets read 0.
- R3: A pulse on `ev_sbe`, `ev_dbe` or `ev_drop` sets bit 2, bit 3 or bit 4 of the status register (offset 0x38). The bit stays set until a clear command. Writes to offset 0x38 have no effect.
- R4: Each `ev_sbe` pulse increments the 4-bit counter at offset 0x40, and each `ev_dbe` pulse increments the counter at offset 0x44. Both counters hold at 15.
- R5: Offset 0x48 holds an error address. A double-bit event always loads `ev_addr` into it. A single-bit or dropped-correction event loads it only when no double-bit error is pending.
- R6: Offset 0x3C bit 0 is the interrupt enable. Bits 1, 2 and 3 mask the single-bit, double-bit and dropped-correction sources (1 = masked). `irq` is the enable ANDed with the OR of the pending flags whose mask bit is 0.
- R7: A write to offset 0x3C with bit 4 set clears all status flags and both counters. In the same write, bits 3:0 load the enable and the masks. `irq` is low in the cycle after the write. Bit 4 always reads 0.
- R8: An event that arrives in the same cycle as a clear command is kept: its status flag is set, its counter reads 1, and the address rule of R5 applies as if nothing were pending.
- R9: When control bit 14 is set, `wr_code_out` is `wr_code_in` with bits 0 and 1 inverted. Otherwise, when bit 13 is set, only bit 0 is inverted. Otherwise `wr_code_out` passes `wr_code_in` through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (8) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| ev_sbe | input | 1 | Corrected single-bit error pulse |
| ev_dbe | input | 1 | Uncorrectable double-bit error pulse |
| ev_drop | input | 1 | Dropped correction pulse |
| ev_addr | input | ADDR_W (32) | Failing address for the event pulses |
| wr_code_in | input | DATA_W+ECC_W (40) | Encoded write codeword from the encoder |
| wr_code_out | output | DATA_W+ECC_W (40) | Codeword sent to memory, possibly corrupted |
| ecc_en | output | 1 | ECC enable control bit |
| corr_en | output | 1 | Correction enable control bit |
| irq | output | 1 | Level interrupt |

## Verification
The main function is exercised in several ways. Isolated single events show that each source sets its own flag and only its own. Runs of more than fifteen events of one kind separate a saturating counter from a wrapping one. A double-bit event followed by single-bit and drop events tells the address-priority rule apart from plain last-write capture. Clear writes are made both with and without a same-cycle event, so a clear that silently drops an error is caught. Constrained-random traffic mixes all event kinds with random enable, mask and clear writes, and a bench model checks the interrupt level and every register after each cycle.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;

  localparam int unsigned OFS_CTRL  = 32'h00;
  localparam int unsigned OFS_WIDTH = 32'h30;
  localparam int unsigned OFS_STAT  = 32'h38;
  localparam int unsigned OFS_INT   = 32'h3C;
  localparam int unsigned OFS_CSBE  = 32'h40;
  localparam int unsigned OFS_CDBE  = 32'h44;
  localparam int unsigned OFS_EADDR = 32'h48;

  localparam int unsigned CTL_ECC   = 10;
  localparam int unsigned CTL_CORR  = 11;
  localparam int unsigned CTL_INJ1  = 13;
  localparam int unsigned CTL_INJ2  = 14;

  localparam int unsigned STS_SBE   = 2;
  localparam int unsigned STS_DBE   = 3;
  localparam int unsigned STS_DROP  = 4;

  localparam int unsigned INT_EN    = 0;
  localparam int unsigned INT_MSBE  = 1;
  localparam int unsigned INT_MDBE  = 2;
  localparam int unsigned INT_MDROP = 3;
  localparam int unsigned INT_CLR   = 4;

  typedef struct packed {
    logic drop;
    logic dbe;
    logic sbe;
  } ecc_evt_t;

  // Interrupt level from enable, pending flags and masks.
  function automatic logic irq_eval(logic en, ecc_evt_t pend, ecc_evt_t mask);
    return en & (|(pend & ~mask));
  endfunction

  // Address capture rule: a double-bit event always wins; other events
  // only when no double-bit error remains pending after this cycle's clear.
  function automatic logic addr_take(ecc_evt_t ev, logic dbe_held);
    return ev.dbe | ((ev.sbe | ev.drop) & ~dbe_held);
  endfunction

endpackage

// File: rtl/ecc_sat_cnt.sv
module ecc_sat_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (inc)      cnt_d = clr ? ONE : ((cnt_q == TOP) ? cnt_q : cnt_q + ONE);
    else if (clr) cnt_d = '0;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ecc_evt_track.sv
module ecc_evt_track
  import ecc_err_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  ecc_evt_t          ev,
  input  logic [ADDR_W-1:0] ev_addr,
  output ecc_evt_t          pend,
  output logic [CNT_W-1:0]  cnt_sbe,
  output logic [CNT_W-1:0]  cnt_dbe,
  output logic [ADDR_W-1:0] err_addr
);
  localparam int unsigned NSRC = $bits(ecc_evt_t);
  localparam int unsigned NCNT = 2;

  logic [NSRC-1:0]   pend_q;
  logic [NSRC-1:0]   ev_v;
  logic [ADDR_W-1:0] addr_q;
  logic              dbe_held;
  logic              take;
  logic [CNT_W-1:0]  cnts [NCNT];
  logic [NCNT-1:0]   cnt_inc;

  assign ev_v     = ev;
  assign dbe_held = pend_q[1] & ~clr;
  assign take     = addr_take(ev, dbe_held);
  assign cnt_inc  = {ev.dbe, ev.sbe};

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q[i] <= 1'b0;
      else if (ev_v[i])  pend_q[i] <= 1'b1;
      else if (clr)      pend_q[i] <= 1'b0;
    end
  end

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    ecc_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .inc  (cnt_inc[k]),
      .cnt  (cnts[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (take) addr_q <= ev_addr;
  end

  assign pend     = pend_q;
  assign cnt_sbe  = cnts[0];
  assign cnt_dbe  = cnts[1];
  assign err_addr = addr_q;
endmodule

// File: rtl/ecc_inj_path.sv
module ecc_inj_path #(
  parameter int unsigned CW = 40
) (
  input  logic          inj_one,
  input  logic          inj_two,
  input  logic [CW-1:0] code_in,
  output logic [CW-1:0] code_out
);
  function automatic logic [CW-1:0] flip_mask(logic one, logic two);
    logic [CW-1:0] m;
    m = '0;
    if (two)      m[1:0] = 2'b11;
    else if (one) m[0]   = 1'b1;
    return m;
  endfunction

  assign code_out = code_in ^ flip_mask(inj_one, inj_two);
endmodule

// File: rtl/ecc_err_unit.sv
module ecc_err_unit
  import ecc_err_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ECC_W  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned REG_AW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [REG_AW-1:0]         reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  input  logic                      ev_sbe,
  input  logic                      ev_dbe,
  input  logic                      ev_drop,
  input  logic [ADDR_W-1:0]         ev_addr,
  input  logic [DATA_W+ECC_W-1:0]   wr_code_in,
  output logic [DATA_W+ECC_W-1:0]   wr_code_out,
  output logic                      ecc_en,
  output logic                      corr_en,
  output logic                      irq
);
  localparam int unsigned CW = DATA_W + ECC_W;

  logic     ctl_ecc_q, ctl_corr_q, ctl_inj1_q, ctl_inj2_q;
  logic     int_en_q;
  ecc_evt_t mask_q;

  logic     wr_ctrl, wr_int, clr_cmd, ev_any;
  ecc_evt_t ev, pend;
  logic [CNT_W-1:0]  cnt_sbe, cnt_dbe;
  logic [ADDR_W-1:0] err_addr;

  assign ev      = '{drop: ev_drop, dbe: ev_dbe, sbe: ev_sbe};
  assign ev_any  = ev_sbe | ev_dbe | ev_drop;
  assign wr_ctrl = reg_we && (reg_addr == REG_AW'(OFS_CTRL));
  assign wr_int  = reg_we && (reg_addr == REG_AW'(OFS_INT));
  assign clr_cmd = wr_int && reg_wdata[INT_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_ecc_q  <= 1'b0;
      ctl_corr_q <= 1'b0;
      ctl_inj1_q <= 1'b0;
      ctl_inj2_q <= 1'b0;
    end else if (wr_ctrl) begin
      ctl_ecc_q  <= reg_wdata[CTL_ECC];
      ctl_corr_q <= reg_wdata[CTL_CORR];
      ctl_inj1_q <= reg_wdata[CTL_INJ1];
      ctl_inj2_q <= reg_wdata[CTL_INJ2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en_q <= 1'b0;
      mask_q   <= '0;
    end else if (wr_int) begin
      int_en_q <= reg_wdata[INT_EN];
      mask_q   <= '{drop: reg_wdata[INT_MDROP], dbe: reg_wdata[INT_MDBE],
                    sbe: reg_wdata[INT_MSBE]};
    end
  end

  ecc_evt_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_cmd),
    .ev      (ev),
    .ev_addr (ev_addr),
    .pend    (pend),
    .cnt_sbe (cnt_sbe),
    .cnt_dbe (cnt_dbe),
    .err_addr(err_addr)
  );

  ecc_inj_path #(.CW(CW)) u_inj (
    .inj_one (ctl_inj1_q),
    .inj_two (ctl_inj2_q),
    .code_in (wr_code_in),
    .code_out(wr_code_out)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_AW'(OFS_CTRL): begin
        reg_rdata[CTL_ECC]  = ctl_ecc_q;
        reg_rdata[CTL_CORR] = ctl_corr_q;
        reg_rdata[CTL_INJ1] = ctl_inj1_q;
        reg_rdata[CTL_INJ2] = ctl_inj2_q;
      end
      REG_AW'(OFS_WIDTH): reg_rdata = 32'(CW);
      REG_AW'(OFS_STAT): begin
        reg_rdata[STS_SBE]  = pend.sbe;
        reg_rdata[STS_DBE]  = pend.dbe;
        reg_rdata[STS_DROP] = pend.drop;
      end
      REG_AW'(OFS_INT): begin
        reg_rdata[INT_EN]    = int_en_q;
        reg_rdata[INT_MSBE]  = mask_q.sbe;
        reg_rdata[INT_MDBE]  = mask_q.dbe;
        reg_rdata[INT_MDROP] = mask_q.drop;
      end
      REG_AW'(OFS_CSBE):  reg_rdata[CNT_W-1:0]  = cnt_sbe;
      REG_AW'(OFS_CDBE):  reg_rdata[CNT_W-1:0]  = cnt_dbe;
      REG_AW'(OFS_EADDR): reg_rdata[ADDR_W-1:0] = err_addr;
      default: reg_rdata = '0;
    endcase
  end

  assign irq     = irq_eval(int_en_q, pend, mask_q);
  assign ecc_en  = ctl_ecc_q;
  assign corr_en = ctl_corr_q;
endmodule

// File: rtl/ecc_err_unit_chk.sv
module ecc_err_unit_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned CW     = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              clr_cmd,
  input logic              ev_any,
  input logic              ev_dbe,
  input logic [ADDR_W-1:0] ev_addr,
  input logic              pend_sbe,
  input logic              pend_dbe,
  input logic [CNT_W-1:0]  cnt_sbe,
  input logic [ADDR_W-1:0] err_addr,
  input logic              int_en,
  input logic              inj1,
  input logic              inj2,
  input logic [CW-1:0]     code_in,
  input logic [CW-1:0]     code_out
);
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_sbe && !clr_cmd) |=> pend_sbe);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_sbe == {CNT_W{1'b1}} && !clr_cmd) |=> cnt_sbe == {CNT_W{1'b1}});

  assert_dbe_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dbe |=> err_addr == $past(ev_addr));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_dbe && !clr_cmd && !ev_dbe) |=> $stable(err_addr));

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq);

  assert_clear_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd && !ev_any) |=> !irq);

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dbe && clr_cmd) |=> pend_dbe);

  assert_flip_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(code_in ^ code_out) <= 2);

  assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!inj1 && !inj2) |-> code_out == code_in);
endmodule

bind ecc_err_unit ecc_err_unit_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CW(DATA_W + ECC_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .clr_cmd (clr_cmd),
  .ev_any  (ev_any),
  .ev_dbe  (ev_dbe),
  .ev_addr (ev_addr),
  .pend_sbe(pend.sbe),
  .pend_dbe(pend.dbe),
  .cnt_sbe (cnt_sbe),
  .err_addr(err_addr),
  .int_en  (int_en_q),
  .inj1    (ctl_inj1_q),
  .inj2    (ctl_inj2_q),
  .code_in (wr_code_in),
  .code_out(wr_code_out)
);

// File: tb/ecc_err_unit_bench.sv
module ecc_err_unit_bench;
  localparam int CW = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_sbe = 1'b0, ev_dbe = 1'b0, ev_drop = 1'b0;
  logic [31:0] ev_addr = '0;
  logic [CW-1:0] wr_code_in = '0;
  logic [CW-1:0] wr_code_out;
  logic        ecc_en, corr_en, irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ecc_err_unit u_ecc_err_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_sbe(ev_sbe),
    .ev_dbe(ev_dbe), .ev_drop(ev_drop), .ev_addr(ev_addr),
    .wr_code_in(wr_code_in), .wr_code_out(wr_code_out),
    .ecc_en(ecc_en), .corr_en(corr_en), .irq(irq)
  );

  // Reference state: index 0 single, 1 double, 2 drop
  logic [2:0]  m_pend = '0, m_mask = '0;
  logic        m_en = 1'b0;
  logic [3:0]  m_cs = '0, m_cd = '0;
  logic [31:0] m_addr = '0, m_ctrl = '0;

  function automatic logic exp_irq();
    return m_en && ((m_pend & ~m_mask) != 3'b000);
  endfunction

  function automatic logic [3:0] bump(logic [3:0] c, logic hit, logic clr);
    if (hit) return clr ? 4'd1 : ((c == 4'd15) ? 4'd15 : c + 4'd1);
    return clr ? 4'd0 : c;
  endfunction

  function automatic logic [CW-1:0] exp_code(logic [31:0] ctl, logic [CW-1:0] c);
    if (ctl[14]) return c ^ CW'(3);
    if (ctl[13]) return c ^ CW'(1);
    return c;
  endfunction

  task automatic check(logic ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(logic we, logic [7:0] a, logic [31:0] wd,
                       logic s, logic d, logic dr, logic [31:0] ea);
    logic clr;
    clr = we && a == 8'h3C && wd[4];
    if (d || ((s || dr) && !(m_pend[1] && !clr))) m_addr = ea;
    m_cs   = bump(m_cs, s, clr);
    m_cd   = bump(m_cd, d, clr);
    m_pend = (clr ? 3'b000 : m_pend) | {dr, d, s};
    if (we && a == 8'h3C) begin m_en = wd[0]; m_mask = wd[3:1]; end
    if (we && a == 8'h00) m_ctrl = wd & 32'h0000_6C00;
  endtask

  // One clock with stimulus; returns at the following falling edge, inputs idle
  task automatic step(logic we, logic [7:0] a, logic [31:0] wd,
                      logic s, logic d, logic dr, logic [31:0] ea);
    reg_we = we; reg_addr = a; reg_wdata = wd;
    ev_sbe = s; ev_dbe = d; ev_drop = dr; ev_addr = ea;
    @(posedge clk);
    model(we, a, wd, s, d, dr, ea);
    @(negedge clk);
    reg_we = 1'b0; ev_sbe = 1'b0; ev_dbe = 1'b0; ev_drop = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic check_all(string ctx);
    logic [31:0] v;
    check(irq == exp_irq(), {"R6 irq ", ctx}, 64'(irq), 64'(exp_irq()));
    rd(8'h38, v); check(v == {27'd0, m_pend, 2'b00}, {"R3 status ", ctx}, 64'(v), 64'({m_pend, 2'b00}));
    rd(8'h40, v); check(v == 32'(m_cs), {"R4 sbe count ", ctx}, 64'(v), 64'(m_cs));
    rd(8'h44, v); check(v == 32'(m_cd), {"R4 dbe count ", ctx}, 64'(v), 64'(m_cd));
    rd(8'h48, v); check(v == m_addr, {"R5 err addr ", ctx}, 64'(v), 64'(m_addr));
    rd(8'h3C, v); check(v == {28'd0, m_mask, m_en}, {"R7 int reg ", ctx}, 64'(v), 64'({m_mask, m_en}));
    rd(8'h00, v); check(v == m_ctrl, {"R2 ctrl ", ctx}, 64'(v), 64'(m_ctrl));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [CW-1:0] c;
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all("R1 reset");
    rd(8'h30, v); check(v == 32'd40, "R2 width", 64'(v), 64'd40);
    rd(8'h10, v); check(v == 32'd0, "R2 unmapped", 64'(v), 64'd0);
    wr_code_in = 40'h12_3456_789A; #1;
    check(wr_code_out == wr_code_in, "R1 code pass", 64'(wr_code_out), 64'(wr_code_in));

    // R2 control bits
    step(1, 8'h00, 32'hFFFF_FFFF, 0, 0, 0, 0);
    check_all("R2 all ones");
    check(ecc_en && corr_en, "R2 enable pins", 64'({ecc_en, corr_en}), 64'd3);
    step(1, 8'h00, 32'h0000_0C00, 0, 0, 0, 0);

    // R3/R6 single event
    step(1, 8'h3C, 32'h11, 0, 0, 0, 0);
    step(0, 8'h00, 0, 1, 0, 0, 32'hA000_0010);
    check_all("R3 sbe");
    check(irq == 1'b1, "R6 irq on sbe", 64'(irq), 64'd1);

    // R5 address priority
    step(0, 8'h00, 0, 0, 1, 0, 32'hB000_0020);
    step(0, 8'h00, 0, 1, 0, 0, 32'hC000_0030);
    step(0, 8'h00, 0, 0, 0, 1, 32'hD000_0040);
    rd(8'h48, v); check(v == 32'hB000_0020, "R5 dbe holds addr", 64'(v), 64'hB000_0020);
    check_all("R5 priority");

    // R4 saturation
    for (int i = 0; i < 20; i++) step(0, 8'h00, 0, 1, 1, 0, 32'(i));
    rd(8'h40, v); check(v == 32'd15, "R4 sbe saturate", 64'(v), 64'd15);
    rd(8'h44, v); check(v == 32'd15, "R4 dbe saturate", 64'(v), 64'd15);

    // R3 write to status ignored
    step(1, 8'h38, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step(1, 8'h3C, 32'h11, 0, 0, 0, 0);
    step(0, 8'h00, 0, 0, 0, 1, 32'h55);
    step(1, 8'h38, 32'h0000_0000, 0, 0, 0, 0);
    check_all("R3 status write ignored");

    // R6 masks
    step(1, 8'h3C, 32'h0F, 0, 0, 0, 0);
    check(irq == 1'b0, "R6 masked", 64'(irq), 64'd0);
    step(1, 8'h3C, 32'h07, 0, 0, 0, 0);
    check(irq == 1'b1, "R6 drop unmasked", 64'(irq), 64'd1);

    // R7 clear
    step(1, 8'h3C, 32'h11, 0, 0, 0, 0);
    check(irq == 1'b0, "R7 irq after clear", 64'(irq), 64'd0);
    check_all("R7 clear");

    // R8 event with clear
    step(0, 8'h00, 0, 0, 1, 0, 32'h1111);
    step(1, 8'h3C, 32'h11, 1, 1, 0, 32'h2222);
    rd(8'h44, v); check(v == 32'd1, "R8 count one", 64'(v), 64'd1);
    rd(8'h48, v); check(v == 32'h2222, "R8 addr", 64'(v), 64'h2222);
    check(irq == 1'b1, "R8 irq", 64'(irq), 64'd1);
    check_all("R8 clear race");

    // R6 clear alone leaves irq disabled
    step(1, 8'h3C, 32'h10, 0, 0, 0, 0);
    step(0, 8'h00, 0, 1, 0, 0, 32'h3333);
    check(irq == 1'b0, "R6 disabled", 64'(irq), 64'd0);
    check_all("R6 disabled");

    // R9 injection
    for (int k = 0; k < 4; k++) begin
      logic [31:0] cw;
      cw = (k == 0) ? 32'h2C00 : (k == 1) ? 32'h4C00 : (k == 2) ? 32'h6C00 : 32'h0C00;
      step(1, 8'h00, cw, 0, 0, 0, 0);
      for (int j = 0; j < 3; j++) begin
        c = {8'($urandom), $urandom};
        wr_code_in = c; #1;
        check(wr_code_out == exp_code(m_ctrl, c), "R9 inject",
              64'(wr_code_out), 64'(exp_code(m_ctrl, c)));
      end
    end

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic we;
      logic [7:0] a;
      logic [31:0] wd;
      we = ($urandom % 6) == 0;
      a  = (($urandom % 4) == 0) ? 8'h00 : 8'h3C;
      wd = $urandom;
      if ((($urandom % 3) == 0)) wd[3:1] = 3'b000;
      step(we, a, wd, ($urandom % 5) == 0, ($urandom % 9) == 0,
           ($urandom % 7) == 0, $urandom);
      check_all("random R3 R4 R5 R6 R7 R8");
      c = {8'($urandom), $urandom};
      wr_code_in = c; #1;
      check(wr_code_out == exp_code(m_ctrl, c), "R9 random",
            64'(wr_code_out), 64'(exp_code(m_ctrl, c)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule